// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block is a clocked, single-channel monostable. A qualified edge on one of its two trigger inputs starts one output pulse. The pulse length in clock cycles comes from a programmable width input, which takes the place of external timing parts. There are two trigger inputs. `trig_n` fires on a falling edge and `trig_p` fires on a rising edge. Each one is qualified by the level of the other. While a pulse runs, further trigger activity is ignored, so the block cannot be retriggered. An active-low clear forces the output low and cuts short any pulse in progress.

A small conditioning latch lets the release of the clear act as a trigger. The latch is armed when, with clear released, `trig_n` is high or `trig_p` is low. A later rising edge of clear then fires a pulse if, at that moment, `trig_n` is low and `trig_p` is high. Starting a pulse disarms the latch.

All three control inputs pass through synchronizers before edge detection, so they may be asynchronous to `clk`. The outputs `q` and `q_n` are always complementary.

Top module: `oneshot_pulse`

## Requirements
- R1: While the synchronized clear is low, `q` is 0. A pulse in progress ends on the third clock edge after `clr_n` falls. Trigger edges seen while clear is low start nothing.
- R2: With clear high, a falling edge on `trig_n` while `trig_p` is high starts a pulse.
- R3: With clear high, a rising edge on `trig_p` while `trig_n` is low starts a pulse.
- R4: While `trig_n` is high or `trig_p` is low, edges on the other trigger input start no pulse, and `q` stays 0.
- R5: Trigger edges that arrive while a pulse runs have no effect: no extension, no restart, no second pulse.
- R6: A rising edge of clear starts a pulse when `trig_n` is low, `trig_p` is high, and the conditioning latch is armed.
- R7: The latch is armed while clear is high and either `trig_n` is high or `trig_p` is low. It is disarmed when a pulse starts, and it resets disarmed. A clear release with the latch disarmed starts no pulse.
- R8: During and after reset, `q` is 0 and `q_n` is 1, and no pulse appears without a trigger.
- R9: The pulse length does not depend on how long the trigger input stays active, whether that is shorter or longer than the pulse.
- R10: `width` is sampled when the pulse starts. The pulse lasts exactly max(`width`,1) cycles, so a width of 0 gives 1 cycle. Changing `width` during a pulse does not alter that pulse.
- R11: `q_n` is the exact complement of `q` in every cycle.
- R12: `q` rises on the third rising clock edge after the input change that triggers it (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_n | input | 1 | Active-low trigger, fires on a falling edge |
| trig_p | input | 1 | Active-high trigger, fires on a rising edge |
| clr_n | input | 1 | Active-low clear; its rising edge can trigger |
| width | input | CW (16) | Pulse length in clock cycles, 0 acts as 1 |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
Two functions can land in the same cycle: a trigger edge, and the clear being asserted. A third case pairs a trigger edge with the last cycle of a running pulse. The bench drops `trig_n` in the same cycle that it pulls `clr_n` low, and expects no pulse. It then releases the clear with the latch armed and expects exactly one pulse of the programmed width, produced by the clear edge. A retrigger edge placed inside a running pulse, together with a width change, must leave the pulse length unchanged. The monitor judges every pulse by its measured high-cycle count against the expected queue entry. Any pulse with no expected entry is reported as a failure.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Effective pulse length: a zero setting still yields one cycle.
  function automatic int unsigned eff_width(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction

  // Count loaded at pulse start: cycles remaining after the first one.
  function automatic int unsigned load_count(input int unsigned w);
    return eff_width(w) - 1;
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int N       = 3,
  parameter int STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[i] <= RST_VAL;
        end else if (i == 0) begin
          stage[i] <= d;
        end else begin
          stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/os_trigger_detect.sv
module os_trigger_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic a_s,     // synchronized active-low trigger
  input  logic b_s,     // synchronized active-high trigger
  input  logic c_s,     // synchronized clear (active low)
  input  logic busy,
  output logic fire_a,
  output logic fire_b,
  output logic fire_c,
  output logic arm,
  output logic start
);
  logic a_p, b_p, c_p;
  logic arm_set;

  // Previous samples; reset to the inactive levels so no edge is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p <= 1'b1;
      b_p <= 1'b0;
      c_p <= 1'b0;
    end else begin
      a_p <= a_s;
      b_p <= b_s;
      c_p <= c_s;
    end
  end

  // Input-edge triggers need the clear released for a full cycle.
  assign fire_a = c_s & c_p & a_p & ~a_s & b_s;
  assign fire_b = c_s & c_p & ~b_p & b_s & ~a_s;
  // Clear-release trigger gated by the conditioning latch.
  assign fire_c = c_s & ~c_p & ~a_s & b_s & arm;

  assign start   = (fire_a | fire_b | fire_c) & ~busy;
  assign arm_set = c_s & (a_s | ~b_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm <= 1'b0;
    end else if (start) begin
      arm <= 1'b0;
    end else if (arm_set) begin
      arm <= 1'b1;
    end
  end
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_s,
  input  logic          start,
  input  logic [CW-1:0] width,
  output logic          q,
  output logic          cnt_zero
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  assign load_val = CW'(oneshot_pkg::load_count(32'(width)));
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!clr_s) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      q   <= 1'b1;
      cnt <= load_val;
    end else if (q) begin
      if (cnt_zero) begin
        q <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_n,
  input  logic          trig_p,
  input  logic          clr_n,
  input  logic [CW-1:0] width,
  output logic          q,
  output logic          q_n
);
  localparam int NSIG = 3;
  // Bit order {clear, trig_p, trig_n}; reset to inactive levels.
  localparam logic [NSIG-1:0] SYNC_RST = 3'b001;

  logic [NSIG-1:0] raw_in, sync_out;
  logic a_s, b_s, clr_s;
  logic fire_a, fire_b, fire_c, arm, start, cnt_zero;

  assign raw_in = {clr_n, trig_p, trig_n};

  os_sync #(.N(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign a_s   = sync_out[0];
  assign b_s   = sync_out[1];
  assign clr_s = sync_out[2];

  os_trigger_detect u_det (
    .clk(clk), .rst_n(rst_n), .a_s(a_s), .b_s(b_s), .c_s(clr_s),
    .busy(q), .fire_a(fire_a), .fire_b(fire_b), .fire_c(fire_c),
    .arm(arm), .start(start)
  );

  os_pulse_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .start(start),
    .width(width), .q(q), .cnt_zero(cnt_zero)
  );

  assign q_n = ~q;
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker (
  input logic clk,
  input logic rst_n,
  input logic clr_s,
  input logic q,
  input logic q_n,
  input logic cnt_zero,
  input logic start,
  input logic fire_a,
  input logic fire_b,
  input logic fire_c,
  input logic arm
);
  p_clear_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> !q);

  p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(fire_a | fire_b | fire_c));

  p_ends_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q && cnt_zero) |=> !q);

  p_clr_edge_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(q) && $past(fire_c) && !$past(fire_a | fire_b)) |-> $past(arm));

  p_arm_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !arm);

  p_holds_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !cnt_zero && clr_s) |=> q);

  p_complement_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_n == !q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_low_r8: assert (!q && q_n);
    end
  end
endmodule

bind oneshot_pulse oneshot_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .q(q), .q_n(q_n),
  .cnt_zero(cnt_zero), .start(start), .fire_a(fire_a), .fire_b(fire_b),
  .fire_c(fire_c), .arm(arm)
);

// File: tb/oneshot_pulse_test.sv
module oneshot_pulse_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_n = 1'b1;
  logic trig_p = 1'b1;
  logic clr_n = 1'b1;
  logic [CW-1:0] width = '0;
  logic q, q_n;

  int checks = 0;
  int errors = 0;
  int pulses_seen = 0;
  int pulses_expected = 0;
  int run_len = 0;
  bit done = 1'b0;
  int expq[$];

  oneshot_pulse #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .trig_p(trig_p),
    .clr_n(clr_n), .width(width), .q(q), .q_n(q_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: one expected pulse length.
  task automatic expect_pulse(input int len);
    expq.push_back(len);
    pulses_expected++;
  endtask

  // Monitor: measures every pulse on q and compares with the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      check(q_n == !q, "R11", q_n, !q);
      if (q) begin
        run_len++;
      end else if (run_len > 0) begin
        pulses_seen++;
        if (expq.size() == 0) begin
          check(1'b0, "R5 unexpected pulse", run_len, 0);
        end else begin
          int e;
          e = expq.pop_front();
          check(run_len == e, "R10 pulse length", run_len, e);
        end
        run_len = 0;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog: actual 1 expected 0");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    // R8: reset state
    step(3);
    check(q == 1'b0 && q_n == 1'b1, "R8 in reset", q, 0);
    rst_n = 1'b1;
    step(10);
    check(q == 1'b0 && q_n == 1'b1, "R8 after reset", q, 0);

    // R2 + R12: falling trig_n with trig_p high, width 5
    width = 5;
    expect_pulse(5);
    trig_n = 1'b0;
    step(2);
    check(q == 1'b0, "R12 not yet", q, 0);
    step(1);
    check(q == 1'b1, "R12 rises third edge", q, 1);
    step(2);
    trig_n = 1'b1;
    step(10);

    // R3: rising trig_p with trig_n low, width 1
    trig_p = 1'b0;
    step(4);
    trig_n = 1'b0;
    step(4);
    check(q == 1'b0, "R4 trig_n fall with trig_p low", q, 0);
    width = 1;
    expect_pulse(1);
    trig_p = 1'b1;
    step(8);
    trig_n = 1'b1;
    step(6);

    // R10: width zero acts as one cycle
    width = 0;
    expect_pulse(1);
    trig_n = 1'b0;
    step(2);
    trig_n = 1'b1;
    step(8);

    // R9: trigger held far longer than the pulse
    width = 3;
    expect_pulse(3);
    trig_n = 1'b0;
    step(50);
    check(q == 1'b0, "R9 long trigger", q, 0);
    trig_n = 1'b1;
    step(6);
    // R9: short trigger, long pulse
    width = 20;
    expect_pulse(20);
    trig_n = 1'b0;
    step(2);
    trig_n = 1'b1;
    step(30);

    // R5 + R10: retrigger ignored, width change mid-pulse ignored
    width = 10;
    expect_pulse(10);
    trig_n = 1'b0;
    step(4);
    trig_n = 1'b1;
    width = 2;
    step(2);
    trig_n = 1'b0;
    step(2);
    check(q == 1'b1, "R5 still in first pulse", q, 1);
    step(16);
    check(q == 1'b0, "R5 no restart", q, 0);
    trig_n = 1'b1;
    step(6);

    // R4: inhibit cases
    trig_p = 1'b0;
    step(4);
    trig_p = 1'b1;           // trig_n high: inhibited
    step(6);
    check(q == 1'b0, "R4 trig_p rise with trig_n high", q, 0);
    trig_p = 1'b0;
    step(4);
    trig_n = 1'b0;           // trig_p low: inhibited
    step(6);
    check(q == 1'b0, "R4 trig_n fall with trig_p low", q, 0);
    trig_n = 1'b1;
    step(4);
    trig_p = 1'b1;
    step(6);

    // R1: clear truncates after 6 cycles, width 30
    width = 30;
    expect_pulse(6);
    trig_n = 1'b0;
    step(2);
    trig_n = 1'b1;
    step(4);
    clr_n = 1'b0;
    step(3);
    check(q == 1'b0 && q_n == 1'b1, "R1 forced low", q, 0);
    trig_n = 1'b0;
    step(2);
    trig_n = 1'b1;
    step(8);
    check(q == 1'b0, "R1 trigger during clear", q, 0);
    clr_n = 1'b1;            // trig_n high here: clear edge does not fire
    step(10);

    // R7: latch disarmed by a pulse start, then clear release does nothing
    width = 4;
    expect_pulse(4);
    trig_n = 1'b0;
    step(12);
    clr_n = 1'b0;
    step(5);
    clr_n = 1'b1;
    step(10);
    check(q == 1'b0, "R7 disarmed clear edge", q, 0);
    trig_n = 1'b1;
    step(6);

    // R6 + R1: trigger edge coinciding with clear, then armed clear release
    width = 7;
    trig_n = 1'b0;
    clr_n = 1'b0;
    step(8);
    check(q == 1'b0, "R1 trigger with clear same cycle", q, 0);
    expect_pulse(7);
    clr_n = 1'b1;
    step(2);
    check(q == 1'b0, "R6 not yet", q, 0);
    step(1);
    check(q == 1'b1, "R6 clear edge fires", q, 1);
    step(12);
    trig_n = 1'b1;
    step(6);

    check(expq.size() == 0, "R5 queue drained", expq.size(), 0);
    check(pulses_seen == pulses_expected, "R5 pulse count", pulses_seen, pulses_expected);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule